// File: doc/BRIEF.md
# Set-Associative Address Translation Buffer with Process-ID Tags

This block caches page translations for a processor core. It maps 4 KB virtual pages to physical frame numbers. Storage is split into `NUM_WAYS` ways, and each way holds `NUM_ENTRIES / NUM_WAYS` sets, a power of two. The low bits of the virtual page number pick the set.

A lookup is purely combinational. The core presents a 32-bit virtual address and its current process ID. In the same cycle the block reports a hit, the 20-bit frame number, and separate read, write and execute permissions. Each entry is either private to one process ID or global to all of them.

A synchronous maintenance port lets software or a page-table walker fill and inspect entries, one at a time, chosen by way and set. Any entry may be written or read this way. The port has no back-pressure: a request is accepted on every clock edge where it is asserted. A read answers with a one-cycle response pulse on the next cycle, and the receiver must take that pulse when it appears. Choosing which way to replace and walking page tables are left to the surrounding logic.

Top module: `tlb_pid_xlate`

## Requirements
- R1: After reset, every tag and data word is zero. A maintenance read of any entry returns zero, and no lookup hits, including virtual address 0 with process ID 0.
- R2: A write request (`mt_req` and `mt_we` high) stores `mt_wtag` unchanged and stores `mt_wdata` with bits [31:24] forced to zero. A read request (`mt_req` high, `mt_we` low) raises `mt_rvalid` for exactly one cycle on the cycle after the request, with that entry's tag and data.
- R3: A write touches only the entry addressed by `mt_way` and `mt_set`. Entries in other ways and other sets keep their contents.
- R4: A lookup hits an entry only if the entry's valid bit (tag bit 10) is set and its stored page number (tag bits [31:12]) equals `lk_vaddr[31:12]`. The set examined in every way is `lk_vaddr[12 +: log2(sets)]`.
- R5: An entry whose global bit (tag bit 11) is clear hits only when tag bits [PID_BITS-1:0] equal `lk_pid`.
- R6: An entry whose global bit is set hits for any `lk_pid`.
- R7: On a hit, `lk_pfn` carries data bits [19:0], `lk_rd` carries data bit 22, `lk_wr` carries data bit 21 and `lk_ex` carries data bit 20. Data bit 23, the cacheable flag, is stored but drives none of the lookup outputs.
- R8: On a miss, `lk_hit`, `lk_pfn`, `lk_rd`, `lk_wr` and `lk_ex` are all zero.
- R9: When several ways hit, the lowest-numbered way supplies the outputs.
- R10: A write is seen by lookups starting immediately after the clock edge that stores it. Before that edge, lookups still see the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_vaddr | input | 32 | Lookup virtual address |
| lk_pid | input | PID_BITS | Current process ID |
| lk_hit | output | 1 | Lookup hit |
| lk_pfn | output | 20 | Physical frame number of the hit |
| lk_rd | output | 1 | Read permitted |
| lk_wr | output | 1 | Write permitted |
| lk_ex | output | 1 | Execute permitted |
| mt_req | input | 1 | Maintenance request strobe |
| mt_we | input | 1 | 1 = write, 0 = read |
| mt_way | input | WAY_W | Way selected for maintenance |
| mt_set | input | SET_W | Set selected for maintenance |
| mt_wtag | input | 32 | Tag word to write |
| mt_wdata | input | 32 | Data word to write |
| mt_rvalid | output | 1 | Read response strobe |
| mt_rtag | output | 32 | Tag word read |
| mt_rdata | output | 32 | Data word read |

## Verification
A corrupted tag bit, whether valid, global, process ID or page number, shows up in the same cycle as a wrong `lk_hit` for an address that should resolve. It is also seen one cycle after a maintenance read of that entry, as a wrong `mt_rtag`. Errors in the set or way decode show up as writes that overwrite a neighbouring entry, so the tests read back or look up entries that were not written. A wrong priority order between ways is only visible when two ways hold the same page, so a duplicate mapping is set up on purpose and its result is then flipped by invalidating the lower way.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int PAGE_SHIFT = 12;
  localparam int VPN_W      = 32 - PAGE_SHIFT;
  localparam int PFN_W      = 20;

  localparam int TAG_GLOBAL_BIT = 11;
  localparam int TAG_VALID_BIT  = 10;

  localparam int DATA_EX_BIT    = 20;
  localparam int DATA_WR_BIT    = 21;
  localparam int DATA_RD_BIT    = 22;
  localparam int DATA_CACHE_BIT = 23;

  localparam logic [31:0] DATA_KEEP_MASK = 32'h00FF_FFFF;

  typedef logic [31:0] word_t;

  typedef struct packed {
    logic             hit;
    logic [PFN_W-1:0] pfn;
    logic             rd;
    logic             wr;
    logic             ex;
  } lookup_res_t;
endpackage

// File: rtl/tlb_way.sv
module tlb_way
  import tlb_pkg::*;
#(
  parameter int SETS     = 16,
  parameter int PID_BITS = 8,
  localparam int SET_W   = (SETS > 1) ? $clog2(SETS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [SET_W-1:0]    wr_set,
  input  word_t               wr_tag,
  input  word_t               wr_data,
  input  logic [SET_W-1:0]    rd_set,
  output word_t               rd_tag,
  output word_t               rd_data,
  input  logic [SET_W-1:0]    lk_set,
  input  logic [VPN_W-1:0]    lk_vpn,
  input  logic [PID_BITS-1:0] lk_pid,
  output logic                hit,
  output word_t               hit_data
);
  word_t tag_q  [SETS];
  word_t data_q [SETS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        tag_q[s]  <= '0;
        data_q[s] <= '0;
      end
    end else if (wr_en) begin
      tag_q[wr_set]  <= wr_tag;
      data_q[wr_set] <= wr_data & DATA_KEEP_MASK;
    end
  end

  assign rd_tag  = tag_q[rd_set];
  assign rd_data = data_q[rd_set];

  word_t sel_tag;
  logic  vpn_eq, pid_eq, is_global, is_valid;

  always_comb begin
    sel_tag   = tag_q[lk_set];
    vpn_eq    = (sel_tag[31:PAGE_SHIFT] == lk_vpn);
    pid_eq    = (sel_tag[PID_BITS-1:0] == lk_pid);
    is_global = sel_tag[TAG_GLOBAL_BIT];
    is_valid  = sel_tag[TAG_VALID_BIT];
    hit       = is_valid && vpn_eq && (is_global || pid_eq);
    hit_data  = data_q[lk_set];
  end

  assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (tag_q[$past(wr_set)] == $past(wr_tag)) &&
              (data_q[$past(wr_set)] == ($past(wr_data) & DATA_KEEP_MASK)));

  assert_hit_needs_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> tag_q[lk_set][TAG_VALID_BIT] && (tag_q[lk_set][31:PAGE_SHIFT] == lk_vpn));

  assert_private_pid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !tag_q[lk_set][TAG_GLOBAL_BIT]) |-> (tag_q[lk_set][PID_BITS-1:0] == lk_pid));
endmodule

// File: rtl/tlb_hit_select.sv
module tlb_hit_select
  import tlb_pkg::*;
#(
  parameter int NUM_WAYS = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_WAYS-1:0]           hit_vec,
  input  logic [NUM_WAYS-1:0][31:0]     data_vec,
  output lookup_res_t                   res
);
  logic [NUM_WAYS-1:0] grant;
  word_t               picked;
  logic [7:0]          unused_hi;

  always_comb begin
    grant = '0;
    for (int i = NUM_WAYS - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        grant    = '0;
        grant[i] = 1'b1;
      end
    end
  end

  always_comb begin
    picked = '0;
    for (int i = 0; i < NUM_WAYS; i++) begin
      picked = picked | (data_vec[i] & {32{grant[i]}});
    end
  end

  assign unused_hi = picked[31:24];

  always_comb begin
    res.hit = |grant;
    res.pfn = picked[PFN_W-1:0];
    res.rd  = picked[DATA_RD_BIT];
    res.wr  = picked[DATA_WR_BIT];
    res.ex  = picked[DATA_EX_BIT];
  end

  assert_single_grant_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && ((grant == '0) == (hit_vec == '0)));

  assert_way0_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hit_vec[0] |-> grant[0]);
endmodule

// File: rtl/tlb_pid_xlate.sv
module tlb_pid_xlate
  import tlb_pkg::*;
#(
  parameter int NUM_WAYS    = 4,
  parameter int NUM_ENTRIES = 64,
  parameter int PID_BITS    = 8,
  localparam int SETS  = NUM_ENTRIES / NUM_WAYS,
  localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1,
  localparam int WAY_W = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [31:0]         lk_vaddr,
  input  logic [PID_BITS-1:0] lk_pid,
  output logic                lk_hit,
  output logic [19:0]         lk_pfn,
  output logic                lk_rd,
  output logic                lk_wr,
  output logic                lk_ex,
  input  logic                mt_req,
  input  logic                mt_we,
  input  logic [WAY_W-1:0]    mt_way,
  input  logic [SET_W-1:0]    mt_set,
  input  logic [31:0]         mt_wtag,
  input  logic [31:0]         mt_wdata,
  output logic                mt_rvalid,
  output logic [31:0]         mt_rtag,
  output logic [31:0]         mt_rdata
);
  logic [VPN_W-1:0]              lk_vpn;
  logic [SET_W-1:0]              lk_set;
  logic [11:0]                   unused_offset;
  logic [NUM_WAYS-1:0]           way_hit;
  logic [NUM_WAYS-1:0][31:0]     way_hdata;
  logic [NUM_WAYS-1:0][31:0]     way_rtag;
  logic [NUM_WAYS-1:0][31:0]     way_rdata;
  lookup_res_t                   res;

  assign lk_vpn        = lk_vaddr[31:PAGE_SHIFT];
  assign lk_set        = lk_vaddr[PAGE_SHIFT +: SET_W];
  assign unused_offset = lk_vaddr[PAGE_SHIFT-1:0];

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    logic wr_sel;
    assign wr_sel = mt_req && mt_we && (mt_way == WAY_W'(w));
    tlb_way #(
      .SETS     (SETS),
      .PID_BITS (PID_BITS)
    ) u_way (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_sel),
      .wr_set   (mt_set),
      .wr_tag   (mt_wtag),
      .wr_data  (mt_wdata),
      .rd_set   (mt_set),
      .rd_tag   (way_rtag[w]),
      .rd_data  (way_rdata[w]),
      .lk_set   (lk_set),
      .lk_vpn   (lk_vpn),
      .lk_pid   (lk_pid),
      .hit      (way_hit[w]),
      .hit_data (way_hdata[w])
    );
  end

  tlb_hit_select #(
    .NUM_WAYS (NUM_WAYS)
  ) u_sel (
    .clk      (clk),
    .rst_n    (rst_n),
    .hit_vec  (way_hit),
    .data_vec (way_hdata),
    .res      (res)
  );

  assign lk_hit = res.hit;
  assign lk_pfn = res.pfn;
  assign lk_rd  = res.rd;
  assign lk_wr  = res.wr;
  assign lk_ex  = res.ex;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mt_rvalid <= 1'b0;
      mt_rtag   <= '0;
      mt_rdata  <= '0;
    end else begin
      mt_rvalid <= mt_req && !mt_we;
      if (mt_req && !mt_we) begin
        mt_rtag  <= way_rtag[mt_way];
        mt_rdata <= way_rdata[mt_way];
      end
    end
  end

  assert_read_answers_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mt_req && !mt_we) |=> mt_rvalid);

  assert_no_stray_resp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(mt_req && !mt_we) |=> !mt_rvalid);

  assert_miss_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (lk_pfn == '0) && !lk_rd && !lk_wr && !lk_ex);
endmodule

// File: tb/tlb_pid_xlate_bench.sv
module tlb_pid_xlate_bench;
  localparam int PID_BITS = 8;
  localparam int WAY_W    = 2;
  localparam int SET_W    = 4;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic [31:0]         lk_vaddr = '0;
  logic [PID_BITS-1:0] lk_pid = '0;
  logic                lk_hit, lk_rd, lk_wr, lk_ex;
  logic [19:0]         lk_pfn;
  logic                mt_req = 1'b0, mt_we = 1'b0;
  logic [WAY_W-1:0]    mt_way = '0;
  logic [SET_W-1:0]    mt_set = '0;
  logic [31:0]         mt_wtag = '0, mt_wdata = '0;
  logic                mt_rvalid;
  logic [31:0]         mt_rtag, mt_rdata;

  int compared = 0;
  int mismatched = 0;

  always #2 clk = ~clk;

  tlb_pid_xlate u_tlb_pid_xlate (
    .clk(clk), .rst_n(rst_n),
    .lk_vaddr(lk_vaddr), .lk_pid(lk_pid),
    .lk_hit(lk_hit), .lk_pfn(lk_pfn), .lk_rd(lk_rd), .lk_wr(lk_wr), .lk_ex(lk_ex),
    .mt_req(mt_req), .mt_we(mt_we), .mt_way(mt_way), .mt_set(mt_set),
    .mt_wtag(mt_wtag), .mt_wdata(mt_wdata),
    .mt_rvalid(mt_rvalid), .mt_rtag(mt_rtag), .mt_rdata(mt_rdata)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_write(input int way, input int set, input logic [31:0] tag, input logic [31:0] data);
    @(negedge clk);
    mt_req = 1'b1; mt_we = 1'b1; mt_way = WAY_W'(way); mt_set = SET_W'(set);
    mt_wtag = tag; mt_wdata = data;
    @(posedge clk);
    @(negedge clk);
    mt_req = 1'b0; mt_we = 1'b0;
  endtask

  task automatic do_read(input string req, input int way, input int set,
                         input logic [31:0] etag, input logic [31:0] edata);
    @(negedge clk);
    mt_req = 1'b1; mt_we = 1'b0; mt_way = WAY_W'(way); mt_set = SET_W'(set);
    @(posedge clk);
    @(negedge clk);
    mt_req = 1'b0;
    check({req, " rvalid"}, {31'd0, mt_rvalid}, 32'd1);
    check({req, " rtag"}, mt_rtag, etag);
    check({req, " rdata"}, mt_rdata, edata);
  endtask

  // expect = {hit, rd, wr, ex, pfn}
  task automatic do_lookup(input string req, input logic [31:0] va, input logic [7:0] pid,
                           input logic hit, input logic [19:0] pfn,
                           input logic r, input logic w, input logic x);
    lk_vaddr = va; lk_pid = pid;
    #1;
    check(req, {8'd0, lk_hit, lk_rd, lk_wr, lk_ex, lk_pfn},
               {8'd0, hit, r, w, x, pfn});
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset_state();
    do_read("R1 reset read w0s0", 0, 0, 32'h0, 32'h0);
    do_read("R1 reset read w3s15", 3, 15, 32'h0, 32'h0);
    @(negedge clk);
    do_lookup("R1 R8 reset lookup va0 pid0", 32'h0, 8'h0, 0, 20'h0, 0, 0, 0);
  endtask

  task automatic t_write_read();
    do_write(1, 5, 32'h1234_543C, 32'hFFF1_2345);
    do_read("R2 tag and masked data", 1, 5, 32'h1234_543C, 32'h00F1_2345);
    @(negedge clk);
    check("R2 rvalid one cycle", {31'd0, mt_rvalid}, 32'd0);
    do_read("R3 other way untouched", 0, 5, 32'h0, 32'h0);
    do_read("R3 other set untouched", 1, 4, 32'h0, 32'h0);
  endtask

  task automatic t_pid_match();
    @(negedge clk);
    do_lookup("R5 R7 own pid hit", 32'h1234_5678, 8'h3C, 1, 20'h12345, 1, 1, 1);
    do_lookup("R5 R8 other pid miss", 32'h1234_5678, 8'h3D, 0, 20'h0, 0, 0, 0);
    do_write(0, 7, 32'h0000_7401, 32'h0040_0055);
    do_lookup("R7 read only", 32'h0000_7ABC, 8'h01, 1, 20'h00055, 1, 0, 0);
    do_write(2, 8, 32'h0000_8401, 32'h0090_0066);
    do_lookup("R7 exec only cache bit hidden", 32'h0000_8000, 8'h01, 1, 20'h00066, 0, 0, 1);
  endtask

  task automatic t_global();
    do_write(2, 9, 32'h0002_9C05, 32'h0060_0077);
    do_lookup("R6 global any pid", 32'h0002_9FFF, 8'h99, 1, 20'h00077, 1, 1, 0);
  endtask

  task automatic t_valid_vpn();
    do_write(3, 10, 32'h0003_A800, 32'h00F0_0011);
    do_lookup("R4 invalid entry misses", 32'h0003_A000, 8'h00, 0, 20'h0, 0, 0, 0);
    do_lookup("R4 vpn mismatch same set", 32'h2234_5000, 8'h3C, 0, 20'h0, 0, 0, 0);
  endtask

  task automatic t_priority();
    do_write(3, 5, 32'h1234_543C, 32'h0010_0099);
    do_lookup("R9 lowest way wins", 32'h1234_5000, 8'h3C, 1, 20'h12345, 1, 1, 1);
    do_write(1, 5, 32'h1234_503C, 32'h00F1_2345);
    do_lookup("R9 next way after invalidate", 32'h1234_5000, 8'h3C, 1, 20'h00099, 0, 0, 1);
  endtask

  task automatic t_write_timing();
    @(negedge clk);
    mt_req = 1'b1; mt_we = 1'b1; mt_way = 2'd0; mt_set = 4'd11;
    mt_wtag = 32'h0000_B402; mt_wdata = 32'h0040_0042;
    do_lookup("R10 before write edge", 32'h0000_B000, 8'h02, 0, 20'h0, 0, 0, 0);
    @(posedge clk);
    #1;
    check("R10 after write edge", {8'd0, lk_hit, lk_rd, lk_wr, lk_ex, lk_pfn},
          {8'd0, 1'b1, 1'b1, 1'b0, 1'b0, 20'h00042});
    @(negedge clk);
    mt_req = 1'b0; mt_we = 1'b0;
  endtask

  task automatic t_reset_clears();
    do_reset();
    do_read("R1 reset clears written", 1, 9 - 4, 32'h0, 32'h0);
    @(negedge clk);
    do_lookup("R1 no hit after reset", 32'h0002_9000, 8'h05, 0, 20'h0, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_write_read();
    t_pid_match();
    t_global();
    t_valid_vpn();
    t_priority();
    t_write_timing();
    t_reset_clears();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(4 * 200000);
    mismatched++;
    $display("FAIL watchdog: actual running expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule